// File: doc/BRIEF.md
# Switching Fault Supervisor with Auto-Restart

This block is the single authority on whether the power stage may switch. Each clock it samples a set of synchronous comparator flags. They cover the supply against its turn-on and turn-off levels, supply over-voltage, the held auxiliary-winding over-voltage, the current-sense shutdown level, and the two temperature flags (hot and cooled). From these it produces a registered run enable for the switching timer and a registered one-hot code naming why switching is stopped.

Every fault has its own recovery rule:

- The supply lockout uses hysteresis between the two supply levels.
- Over-temperature holds the gate off until the cooled flag arrives. It hiccups through supply lockout while the die stays hot.
- Supply over-voltage, auxiliary over-voltage and a shorted output diode are latched. They are released only by a full lockout cycle: the supply falls below the turn-off level and rises again. A fault still present at restart therefore trips again.
- The diode short is recognised only after a parameterised number of consecutive switching cycles with the current-sense flag set. The switching timer marks each cycle with a strobe.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is high and in the first cycle after it, run_en is 0 and fault_code is 5'b00001 (bit 0 = supply lockout).
- R2: In lockout, when vdd_on_ok is 1 and vdd_low is 0 at a clock edge and the die is not hot, run_en becomes 1 and fault_code becomes 0 from that edge on.
- R3: While running, the supply falling between the two levels (vdd_on_ok 0, vdd_low 0) has no effect. vdd_low at an edge stops switching from that edge and sets fault_code to bit 0.
- R4: vdd_over at an edge while running stops switching and latches fault_code bit 2. The code stays after vdd_over clears, until vdd_low is seen.
- R5: aux_over at an edge while running latches fault_code bit 3. If aux_over is still set when switching restarts after a lockout cycle, switching stops again one cycle later.
- R6: A shorted diode latches fault_code bit 4 at the sw_cycle strobe that is the SHORT_CYCLES-th consecutive strobe with cs_over set (default 3). A strobe with cs_over clear restarts the count. cs_over without sw_cycle has no effect.
- R7: temp_hot while running stops switching with fault_code bit 1. The hot condition persists until temp_cool is seen without temp_hot. Switching then resumes on that edge without a lockout cycle.
- R8: vdd_low while hot gives fault_code bit 0. If the supply then reaches the turn-on level while still hot, the code returns to bit 1 with run_en 0. This cycle repeats until the die cools.
- R9: Fixed priority when several flags are set at the same edge while running: vdd_low (bit 0), then hot (bit 1), then vdd_over (bit 2), then aux_over (bit 3), then diode short (bit 4).
- R10: fault_code is 0 exactly when run_en is 1. Otherwise exactly one bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_on_ok | input | 1 | Supply above turn-on level |
| vdd_low | input | 1 | Supply below turn-off level |
| vdd_over | input | 1 | Supply over-voltage |
| aux_over | input | 1 | Held auxiliary-winding over-voltage |
| cs_over | input | 1 | Current sense above shutdown level |
| temp_hot | input | 1 | Die temperature above trip level |
| temp_cool | input | 1 | Die temperature back below the recovery level |
| sw_cycle | input | 1 | One-clock strobe per completed switching cycle |
| run_en | output | 1 | Registered permission to switch |
| fault_code | output | 5 | Registered one-hot stop cause, 0 while running |

## Verification
The stop cause is registered straight from the next state. A wrong state transition therefore appears at run_en and fault_code on the very edge that sampled the flags. A latched fault left with a wrong recovery rule shows as a restart or a stay-off that comes too early, too late or never. A miscounting diode-short counter shows as a bit-4 trip at the wrong strobe. A hot tracker that forgets or sticks shows at the next exit from lockout, when the code goes to bit 1 instead of 0, or the other way round.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOT  = 2'd2,
    ST_HOLD = 2'd3
  } sup_state_t;

  localparam int CAUSE_W = 5;
  localparam int C_UV  = 0;
  localparam int C_OT  = 1;
  localparam int C_SOV = 2;
  localparam int C_AOV = 3;
  localparam int C_DS  = 4;

  function automatic logic [CAUSE_W-1:0] cause_bit(input int idx);
    logic [CAUSE_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/fsup_hot_track.sv
module fsup_hot_track (
  input  logic clk,
  input  logic rst,
  input  logic temp_hot,
  input  logic temp_cool,
  output logic hot_now
);
  logic hot_q;

  assign hot_now = temp_hot | (hot_q & ~temp_cool);

  always_ff @(posedge clk) begin
    if (rst) hot_q <= 1'b0;
    else     hot_q <= hot_now;
  end

  // R7
  hot_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (temp_hot && !temp_cool) |=> hot_q);
endmodule

// File: rtl/fsup_short_count.sv
module fsup_short_count #(
  parameter int unsigned SHORT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick,
  input  logic flag,
  output logic trip
);
  localparam int unsigned CNT_W = $clog2(SHORT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SHORT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign trip = enable & tick & flag & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable || trip) cnt <= '0;
    else if (tick)              cnt <= flag ? cnt + 1'b1 : '0;
  end

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(SHORT_CYCLES));

  // R6
  count_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !flag) |=> (cnt == '0));
endmodule

// File: rtl/fsup_core.sv
module fsup_core
  import fsup_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               vdd_on_ok,
  input  logic               vdd_low,
  input  logic               vdd_over,
  input  logic               aux_over,
  input  logic               short_trip,
  input  logic               hot_now,
  output logic               in_run,
  output logic               run_en,
  output logic [CAUSE_W-1:0] fault_code
);
  sup_state_t        st, nxt;
  logic [CAUSE_W-1:0] hold_cause, hold_nxt, code_nxt;

  assign in_run = (st == ST_RUN);

  always_comb begin
    nxt      = st;
    hold_nxt = hold_cause;
    unique case (st)
      ST_LOCK: if (vdd_on_ok && !vdd_low) nxt = hot_now ? ST_HOT : ST_RUN;
      ST_RUN: begin
        if (vdd_low)      nxt = ST_LOCK;
        else if (hot_now) nxt = ST_HOT;
        else if (vdd_over)   begin nxt = ST_HOLD; hold_nxt = cause_bit(C_SOV); end
        else if (aux_over)   begin nxt = ST_HOLD; hold_nxt = cause_bit(C_AOV); end
        else if (short_trip) begin nxt = ST_HOLD; hold_nxt = cause_bit(C_DS);  end
      end
      ST_HOT: begin
        if (vdd_low)       nxt = ST_LOCK;
        else if (!hot_now) nxt = ST_RUN;
      end
      ST_HOLD: if (vdd_low) nxt = ST_LOCK;
      default: nxt = ST_LOCK;
    endcase
  end

  always_comb begin
    unique case (nxt)
      ST_RUN:  code_nxt = '0;
      ST_HOT:  code_nxt = cause_bit(C_OT);
      ST_HOLD: code_nxt = hold_nxt;
      default: code_nxt = cause_bit(C_UV);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_LOCK;
      hold_cause <= '0;
      run_en     <= 1'b0;
      fault_code <= cause_bit(C_UV);
    end else begin
      st         <= nxt;
      hold_cause <= hold_nxt;
      run_en     <= (nxt == ST_RUN);
      fault_code <= code_nxt;
    end
  end

  // R3
  low_stops_chk: assert property (@(posedge clk) disable iff (rst)
    vdd_low |=> !run_en);

  // R9
  low_first_chk: assert property (@(posedge clk) disable iff (rst)
    vdd_low |=> fault_code[C_UV]);

  // R4
  latched_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ((fault_code[C_SOV] || fault_code[C_AOV] || fault_code[C_DS]) && !vdd_low)
      |=> (fault_code == $past(fault_code)));

  // R7
  hot_stops_chk: assert property (@(posedge clk) disable iff (rst)
    hot_now |=> !run_en);

  // R10
  one_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |-> ($countones(fault_code) == 1));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned SHORT_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vdd_on_ok,
  input  logic               vdd_low,
  input  logic               vdd_over,
  input  logic               aux_over,
  input  logic               cs_over,
  input  logic               temp_hot,
  input  logic               temp_cool,
  input  logic               sw_cycle,
  output logic               run_en,
  output logic [CAUSE_W-1:0] fault_code
);
  logic hot_now, short_trip, in_run;

  fsup_hot_track u_hot (
    .clk(clk), .rst(rst), .temp_hot(temp_hot), .temp_cool(temp_cool),
    .hot_now(hot_now)
  );

  fsup_short_count #(.SHORT_CYCLES(SHORT_CYCLES)) u_cnt (
    .clk(clk), .rst(rst), .enable(in_run), .tick(sw_cycle), .flag(cs_over),
    .trip(short_trip)
  );

  fsup_core u_core (
    .clk(clk), .rst(rst), .vdd_on_ok(vdd_on_ok), .vdd_low(vdd_low),
    .vdd_over(vdd_over), .aux_over(aux_over), .short_trip(short_trip),
    .hot_now(hot_now), .in_run(in_run), .run_en(run_en),
    .fault_code(fault_code)
  );

  // R5
  no_direct_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_code[C_SOV] || fault_code[C_AOV] || fault_code[C_DS]) |=> !run_en);
endmodule

// File: tb/sim_fault_supervisor.sv
`timescale 1ns/1ps
module sim_fault_supervisor;
  localparam int SHORTN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vdd_on_ok = 0, vdd_low = 1, vdd_over = 0, aux_over = 0;
  logic cs_over = 0, temp_hot = 0, temp_cool = 0, sw_cycle = 0;
  logic run_en;
  logic [4:0] fault_code;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_mode = 0, m_lat = 0, m_cnt = 0;
  bit m_hot = 0;

  always #4 clk = ~clk;

  fault_supervisor #(.SHORT_CYCLES(SHORTN)) u0 (
    .clk(clk), .rst(rst), .vdd_on_ok(vdd_on_ok), .vdd_low(vdd_low),
    .vdd_over(vdd_over), .aux_over(aux_over), .cs_over(cs_over),
    .temp_hot(temp_hot), .temp_cool(temp_cool), .sw_cycle(sw_cycle),
    .run_en(run_en), .fault_code(fault_code)
  );

  function automatic int exp_code();
    case (m_mode)
      0: return 1;
      1: return 0;
      2: return 2;
      default: return m_lat;
    endcase
  endfunction

  task automatic check(input string req, input int got_run, input int got_code,
                       input int want_run, input int want_code);
    checks++;
    if (got_run != want_run || got_code != want_code) begin
      fails++;
      $display("FAIL %s: run_en=%0d fault_code=%0d expected run_en=%0d fault_code=%0d",
               req, got_run, got_code, want_run, want_code);
    end
  endtask

  // reference model and per-cycle comparison
  always @(posedge clk) begin
    bit hn, trip;
    int nm;
    if (rst) begin
      m_mode = 0; m_lat = 0; m_cnt = 0; m_hot = 0;
    end else begin
      hn   = temp_hot || (m_hot && !temp_cool);
      trip = (m_mode == 1) && sw_cycle && cs_over && (m_cnt == SHORTN - 1);
      nm = m_mode;
      if (m_mode == 0) begin
        if (vdd_on_ok && !vdd_low) nm = hn ? 2 : 1;
      end else if (m_mode == 1) begin
        if (vdd_low) nm = 0;
        else if (hn) nm = 2;
        else if (vdd_over) begin nm = 3; m_lat = 4; end
        else if (aux_over) begin nm = 3; m_lat = 8; end
        else if (trip) begin nm = 3; m_lat = 16; end
      end else if (m_mode == 2) begin
        if (vdd_low) nm = 0;
        else if (!hn) nm = 1;
      end else begin
        if (vdd_low) nm = 0;
      end
      if (m_mode != 1 || trip) m_cnt = 0;
      else if (sw_cycle) m_cnt = cs_over ? m_cnt + 1 : 0;
      m_hot = hn;
      m_mode = nm;
    end
    #3;
    if (!done) check(cur_req, run_en, fault_code, (m_mode == 1) ? 1 : 0, exp_code());
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // directed check after the next edge
  task automatic expect_at_edge(input string req, input int want_run, input int want_code);
    @(posedge clk); #3;
    check(req, run_en, fault_code, want_run, want_code);
    @(negedge clk);
  endtask

  task automatic uvlo_cycle();
    vdd_on_ok = 0; vdd_low = 1; step(2);
    vdd_low = 0; step(2);
    vdd_on_ok = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run_en=%0d fault_code=%0d expected run to end", run_en, fault_code);
    finish_run();
  end

  initial begin
    step(3);
    #1; check("R1", run_en, fault_code, 0, 1);
    @(negedge clk);
    rst = 0;
    expect_at_edge("R1", 0, 1);

    cur_req = "R2";
    vdd_low = 0; vdd_on_ok = 1;
    expect_at_edge("R2", 1, 0);

    cur_req = "R3";
    vdd_on_ok = 0; step(10);
    #1; check("R3", run_en, fault_code, 1, 0);
    vdd_low = 1;
    expect_at_edge("R3", 0, 1);
    vdd_low = 0; step(3);
    #1; check("R3", run_en, fault_code, 0, 1);
    vdd_on_ok = 1;
    expect_at_edge("R2", 1, 0);

    cur_req = "R4";
    vdd_over = 1;
    expect_at_edge("R4", 0, 4);
    vdd_over = 0; step(20);
    #1; check("R4", run_en, fault_code, 0, 4);
    uvlo_cycle();
    expect_at_edge("R4", 1, 0);

    cur_req = "R5";
    aux_over = 1;
    expect_at_edge("R5", 0, 8);
    uvlo_cycle();
    expect_at_edge("R5", 1, 0);
    expect_at_edge("R5", 0, 8);
    aux_over = 0;
    uvlo_cycle();
    expect_at_edge("R5", 1, 0);

    cur_req = "R6";
    for (int k = 0; k < 2; k++) begin
      cs_over = 1; sw_cycle = 1; step(1); sw_cycle = 0; step(2);
    end
    cs_over = 0; sw_cycle = 1; step(1); sw_cycle = 0; step(1);
    for (int k = 0; k < 2; k++) begin
      cs_over = 1; sw_cycle = 1; step(1); sw_cycle = 0; step(2);
    end
    cs_over = 1; step(30);
    #1; check("R6", run_en, fault_code, 1, 0);
    sw_cycle = 1;
    expect_at_edge("R6", 0, 16);
    sw_cycle = 0; cs_over = 0;
    uvlo_cycle();
    expect_at_edge("R6", 1, 0);

    cur_req = "R7";
    temp_hot = 1;
    expect_at_edge("R7", 0, 2);
    temp_hot = 0; step(10);
    #1; check("R7", run_en, fault_code, 0, 2);
    temp_cool = 1;
    expect_at_edge("R7", 1, 0);
    temp_cool = 0;

    cur_req = "R8";
    temp_hot = 1; step(2); temp_hot = 0;
    vdd_on_ok = 0; vdd_low = 1;
    expect_at_edge("R8", 0, 1);
    vdd_low = 0; vdd_on_ok = 1;
    expect_at_edge("R8", 0, 2);
    vdd_on_ok = 0; vdd_low = 1;
    expect_at_edge("R8", 0, 1);
    vdd_low = 0; vdd_on_ok = 1;
    expect_at_edge("R8", 0, 2);
    temp_cool = 1;
    expect_at_edge("R8", 1, 0);
    temp_cool = 0;

    cur_req = "R9";
    vdd_over = 1; aux_over = 1; cs_over = 1; sw_cycle = 1;
    expect_at_edge("R9", 0, 4);
    vdd_over = 0; aux_over = 0; cs_over = 0; sw_cycle = 0;
    uvlo_cycle();
    expect_at_edge("R9", 1, 0);
    temp_hot = 1; vdd_over = 1;
    expect_at_edge("R9", 0, 2);
    temp_hot = 0; vdd_over = 0; temp_cool = 1;
    expect_at_edge("R9", 1, 0);
    temp_cool = 0;
    vdd_low = 1; vdd_on_ok = 0; temp_hot = 1; aux_over = 1;
    expect_at_edge("R9", 0, 1);
    temp_hot = 0; aux_over = 0; temp_cool = 1; step(2); temp_cool = 0;
    vdd_low = 0; vdd_on_ok = 1; step(2);

    cur_req = "R10";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom % 100;
      vdd_low   = (r < 3);
      vdd_on_ok = (r > 20) ? 1'b1 : ($urandom % 2 == 0);
      vdd_over  = ($urandom % 60 == 0);
      aux_over  = ($urandom % 60 == 0);
      cs_over   = ($urandom % 3 != 0);
      sw_cycle  = ($urandom % 2 == 0);
      temp_hot  = ($urandom % 80 == 0);
      temp_cool = ($urandom % 10 == 0);
      step(1);
    end
    step(2);
    finish_run();
  end
endmodule